// File: doc/BRIEF.md
# CPU Condition Code Flag Unit

This block holds the 8-bit condition code register of a small 8-bit accumulator CPU and works out its next value. Each cycle the surrounding core may present the two ALU operands, the ALU result and an operation class. When the update strobe is high, the unit derives overflow, half-carry, negative, zero and carry from those values. It does not use the ALU's own carry wires, so the flags stay consistent with whatever result the datapath produced.

The interrupt mask bit follows the interrupt entry and exit sequence of the core. The mask sets on the cycle after the core reports that its registers have been saved. A clear-mask strobe that arrives in the same cycle as that report, or during the vector-fetch step, is ignored. On return from interrupt the whole register, mask included, is reloaded from the byte the core pulled off the stack. A direct write loads the whole register at once. The `irq_masked` output gates maskable interrupt requests elsewhere in the core.

Top module: `ccr_unit`

## Requirements
- R1: `ccr_q` packs the flags as bit 7 overflow, bit 4 half-carry, bit 3 mask, bit 2 negative, bit 1 zero, bit 0 carry. Bits 6 and 5 read 1 at all times, including right after a load whose data has 0 in those positions.
- R2: For add (class 1), add-with-carry (class 2) and subtract (class 3), overflow is set exactly when the signed result overflows. A logic operation (class 4) clears overflow.
- R3: For classes 1 and 2, half-carry is set exactly when a carry passes from bit 3 into bit 4, counting the carry input. Classes 3 and 4 leave half-carry unchanged.
- R4: For classes 1 to 4, negative takes bit 7 of the result, and zero is set exactly when the 8-bit result is zero.
- R5: Carry takes the carry out of bit 7 for classes 1 and 2, and takes the borrow (operand A below operand B, unsigned) for class 3. Class 4 leaves carry unchanged. Class 2 adds the current carry as carry input.
- R6: Flags change on an operation only when `flag_upd` is high. Class 0 changes no flag even when `flag_upd` is high.
- R7: While `rst_n` is low, the mask reads 1 and `irq_masked` is 1. The other flags are undefined until written.
- R8: `mask_set` sets the mask at the next edge. Apart from a load, only `mask_clr` clears it, one edge after the strobe.
- R9: `irq_saved` sets the mask at the next edge and wins over `mask_clr` in the same cycle. `mask_clr` is ignored while `irq_vec` is high.
- R10: `rti_load` loads the whole register, mask included, from `rti_byte` at the next edge.
- R11: `wr_en` loads the whole register from `wr_data` at the next edge. `rti_load` wins over `wr_en`, and either load wins over `flag_upd` and all mask strobes.
- R12: `irq_masked` equals bit 3 of `ccr_q` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 8 | ALU operand A (minuend for subtract) |
| opnd_b | input | 8 | ALU operand B |
| alu_res | input | 8 | ALU result for the current operation |
| op_class | input | 3 | 0 none, 1 add, 2 add-with-carry, 3 subtract, 4 logic or data move |
| flag_upd | input | 1 | Apply the operation's flags this cycle |
| irq_saved | input | 1 | Interrupt entry: register save step complete |
| irq_vec | input | 1 | Interrupt entry: vector fetch step |
| mask_set | input | 1 | Set-mask instruction strobe |
| mask_clr | input | 1 | Clear-mask instruction strobe |
| rti_load | input | 1 | Return from interrupt: load restored byte |
| rti_byte | input | 8 | Register image pulled from the stack |
| wr_en | input | 1 | Direct register write strobe |
| wr_data | input | 8 | Direct write data |
| ccr_q | output | 8 | Condition code register value |
| irq_masked | output | 1 | Maskable interrupts blocked |

## Verification
The assertions assume that `alu_res` really is the result of the named class on the presented operands. For add-with-carry, the carry input is the carry flag as it stands before the edge. They also assume that the core never drives the interrupt-entry strobes together with `rti_load`. The bench builds every result from its own operand values and its own carry model, so the operand-to-result relation always holds. It raises entry, return and mask strobes only in the combinations the requirements name. Undefined flags are not compared until a direct write has made them known.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_ADC   = 3'd2,
    OPC_SUB   = 3'd3,
    OPC_LOGIC = 3'd4
  } op_class_e;

  typedef struct packed {
    logic v;
    logic h;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;

  localparam int unsigned CCR_W    = 8;
  localparam int unsigned POS_V    = 7;
  localparam int unsigned POS_H    = 4;
  localparam int unsigned POS_I    = 3;
  localparam int unsigned POS_N    = 2;
  localparam int unsigned POS_Z    = 1;
  localparam int unsigned POS_C    = 0;
  localparam logic [1:0]  FIXED_HI = 2'b11;

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HC_BIT = 3
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  op_class_e         op_class,
  output arith_flags_t      flags_d,
  output arith_flags_t      flags_en
);

  localparam int unsigned MSB = DATA_W - 1;

  logic a_m, b_m, r_m;
  logic a_h, b_h, r_h;
  logic add_v, add_c, add_h;
  logic sub_v, sub_c;
  logic res_n, res_z;

  always_comb begin
    a_m = opnd_a[MSB];
    b_m = opnd_b[MSB];
    r_m = alu_res[MSB];
    a_h = opnd_a[HC_BIT];
    b_h = opnd_b[HC_BIT];
    r_h = alu_res[HC_BIT];

    add_c = (a_m & b_m) | (a_m & ~r_m) | (b_m & ~r_m);
    add_h = (a_h & b_h) | (a_h & ~r_h) | (b_h & ~r_h);
    add_v = (a_m & b_m & ~r_m) | (~a_m & ~b_m & r_m);

    sub_c = (~a_m & b_m) | (~a_m & r_m) | (b_m & r_m);
    sub_v = (a_m & ~b_m & ~r_m) | (~a_m & b_m & r_m);

    res_n = r_m;
    res_z = (alu_res == '0);
  end

  always_comb begin
    flags_d  = '0;
    flags_en = '0;
    flags_d.n = res_n;
    flags_d.z = res_z;
    unique case (op_class)
      OPC_ADD, OPC_ADC: begin
        flags_d.v = add_v;
        flags_d.h = add_h;
        flags_d.c = add_c;
        flags_en  = '1;
      end
      OPC_SUB: begin
        flags_d.v  = sub_v;
        flags_d.c  = sub_c;
        flags_en.v = 1'b1;
        flags_en.n = 1'b1;
        flags_en.z = 1'b1;
        flags_en.c = 1'b1;
      end
      OPC_LOGIC: begin
        flags_d.v  = 1'b0;
        flags_en.v = 1'b1;
        flags_en.n = 1'b1;
        flags_en.z = 1'b1;
      end
      default: begin
        flags_en = '0;
      end
    endcase
  end

  always_comb begin
    if (op_class == OPC_SUB || op_class == OPC_LOGIC)
      AST_H_ONLY_ON_ADD: assert (!flags_en.h); // R3
    if (op_class == OPC_LOGIC)
      AST_LOGIC_KEEPS_C: assert (!flags_en.c && !flags_d.v); // R5
  end

endmodule

// File: rtl/ccr_mask_ctrl.sv
module ccr_mask_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rti_load,
  input  logic rti_mask,
  input  logic wr_en,
  input  logic wr_mask,
  input  logic irq_saved,
  input  logic irq_vec,
  input  logic mask_set,
  input  logic mask_clr,
  output logic mask_q
);

  logic mask_d;
  logic mask_en;

  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    if (rti_load) begin
      mask_d  = rti_mask;
      mask_en = 1'b1;
    end else if (wr_en) begin
      mask_d  = wr_mask;
      mask_en = 1'b1;
    end else if (irq_saved || mask_set) begin
      mask_d  = 1'b1;
      mask_en = 1'b1;
    end else if (mask_clr && !irq_vec) begin
      mask_d  = 1'b0;
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= 1'b1;
    else if (mask_en)
      mask_q <= mask_d;
  end

  AST_ENTRY_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_saved && !rti_load && !wr_en) |=> mask_q); // R9

  AST_VEC_BLOCKS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && irq_vec && !rti_load && !wr_en) |=> mask_q); // R9

  AST_ONLY_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !mask_clr && !rti_load && !wr_en) |=> mask_q); // R8

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr && !irq_vec && !irq_saved && !mask_set && !rti_load && !wr_en) |=> !mask_q); // R8

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HC_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [2:0]        op_class,
  input  logic              flag_upd,
  input  logic              irq_saved,
  input  logic              irq_vec,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              rti_load,
  input  logic [7:0]        rti_byte,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        ccr_q,
  output logic              irq_masked
);

  arith_flags_t alu_flags;
  arith_flags_t alu_en;
  arith_flags_t flag_q;
  arith_flags_t flag_d;
  logic         flag_ld;
  logic [7:0]   load_val;
  logic         mask_q;
  logic         unused_fixed;

  ccr_flag_calc #(
    .DATA_W (DATA_W),
    .HC_BIT (HC_BIT)
  ) u_calc (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .alu_res  (alu_res),
    .op_class (op_class_e'(op_class)),
    .flags_d  (alu_flags),
    .flags_en (alu_en)
  );

  ccr_mask_ctrl u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .rti_load  (rti_load),
    .rti_mask  (rti_byte[POS_I]),
    .wr_en     (wr_en),
    .wr_mask   (wr_data[POS_I]),
    .irq_saved (irq_saved),
    .irq_vec   (irq_vec),
    .mask_set  (mask_set),
    .mask_clr  (mask_clr),
    .mask_q    (mask_q)
  );

  assign load_val     = rti_load ? rti_byte : wr_data;
  assign unused_fixed = ^load_val[6:5];

  always_comb begin
    flag_d  = flag_q;
    flag_ld = 1'b0;
    if (rti_load || wr_en) begin
      flag_d.v = load_val[POS_V];
      flag_d.h = load_val[POS_H];
      flag_d.n = load_val[POS_N];
      flag_d.z = load_val[POS_Z];
      flag_d.c = load_val[POS_C];
      flag_ld  = 1'b1;
    end else if (flag_upd) begin
      if (alu_en.v) flag_d.v = alu_flags.v;
      if (alu_en.h) flag_d.h = alu_flags.h;
      if (alu_en.n) flag_d.n = alu_flags.n;
      if (alu_en.z) flag_d.z = alu_flags.z;
      if (alu_en.c) flag_d.c = alu_flags.c;
      flag_ld = |alu_en;
    end
  end

  always_ff @(posedge clk) begin
    if (flag_ld)
      flag_q <= flag_d;
  end

  assign ccr_q      = {flag_q.v, FIXED_HI, flag_q.h, mask_q, flag_q.n, flag_q.z, flag_q.c};
  assign irq_masked = mask_q;

  AST_RTI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rti_load |=> (ccr_q == ($past(rti_byte) | 8'h60))); // R10

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rti_load) |=> (ccr_q == ($past(wr_data) | 8'h60))); // R11

  AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && op_class == 3'd4 && !rti_load && !wr_en) |=> !ccr_q[POS_V]); // R2

  AST_NOOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_upd && !rti_load && !wr_en) |=> ({ccr_q[7:4], ccr_q[2:0]} == $past({ccr_q[7:4], ccr_q[2:0]}))); // R6

endmodule

// File: tb/ccr_unit_test.sv
module ccr_unit_test;

  logic       clk;
  logic       rst_n;
  logic [7:0] opnd_a, opnd_b, alu_res;
  logic [2:0] op_class;
  logic       flag_upd, irq_saved, irq_vec, mask_set, mask_clr;
  logic       rti_load, wr_en;
  logic [7:0] rti_byte, wr_data;
  logic [7:0] ccr_q;
  logic       irq_masked;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic mv, mh, mi, mn, mz, mc;

  ccr_unit uut (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_res(alu_res), .op_class(op_class), .flag_upd(flag_upd),
    .irq_saved(irq_saved), .irq_vec(irq_vec), .mask_set(mask_set),
    .mask_clr(mask_clr), .rti_load(rti_load), .rti_byte(rti_byte),
    .wr_en(wr_en), .wr_data(wr_data), .ccr_q(ccr_q), .irq_masked(irq_masked)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] model_ccr();
    return {mv, 2'b11, mh, mi, mn, mz, mc};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    flag_upd = 0; irq_saved = 0; irq_vec = 0; mask_set = 0; mask_clr = 0;
    rti_load = 0; wr_en = 0; op_class = 3'd0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_op(input logic [2:0] cls, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    logic [7:0] r;
    logic       cin;
    cin = (cls == 3'd2) ? mc : 1'b0;
    case (cls)
      3'd1, 3'd2: begin
        s  = {1'b0, a} + {1'b0, b} + {8'd0, cin};
        r  = s[7:0];
        mh = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin}) > 5'd15;
        mc = s[8];
        mv = (a[7] == b[7]) && (r[7] != a[7]);
      end
      3'd3: begin
        r  = a - b;
        mc = (a < b);
        mv = (a[7] != b[7]) && (r[7] != a[7]);
      end
      default: begin
        case ($urandom % 4)
          0: r = a & b;
          1: r = a | b;
          2: r = a ^ b;
          default: r = a;
        endcase
        mv = 1'b0;
      end
    endcase
    mn = r[7];
    mz = (r == 8'd0);
    opnd_a = a; opnd_b = b; alu_res = r; op_class = cls; flag_upd = 1;
    step();
    chk("R2 V", {7'd0, ccr_q[7]}, {7'd0, mv});
    chk("R3 H", {7'd0, ccr_q[4]}, {7'd0, mh});
    chk("R4 NZ", {6'd0, ccr_q[2:1]}, {6'd0, mn, mz});
    chk("R5 C", {7'd0, ccr_q[0]}, {7'd0, mc});
  endtask

  task automatic write_ccr(input logic [7:0] d);
    wr_data = d; wr_en = 1;
    step();
    {mv, mh, mi, mn, mz, mc} = {d[7], d[4], d[3], d[2], d[1], d[0]};
    chk("R11 write", ccr_q, model_ccr());
    chk("R1 fixed", ccr_q & 8'h60, 8'h60);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    idle();
    opnd_a = 0; opnd_b = 0; alu_res = 0; rti_byte = 0; wr_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 reset mask", {7'd0, ccr_q[3]}, 8'd1);
    chk("R12 masked in reset", {7'd0, irq_masked}, 8'd1);
    chk("R1 fixed in reset", ccr_q & 8'h60, 8'h60);
    rst_n = 1;
    step();
    chk("R7 mask held after reset", {7'd0, ccr_q[3]}, 8'd1);

    // R8: mask survives idle cycles, clears only on mask_clr
    repeat (3) step();
    chk("R8 mask holds", {7'd0, ccr_q[3]}, 8'd1);
    mask_clr = 1; step(); mi = 0;
    chk("R8 clear", {7'd0, ccr_q[3]}, 8'd0);
    chk("R12 follows", {7'd0, irq_masked}, 8'd0);

    write_ccr(8'h00);
    write_ccr(8'h9f);
    write_ccr(8'h00);

    // directed corners
    do_op(3'd1, 8'h0f, 8'h01);
    do_op(3'd1, 8'h7f, 8'h01);
    do_op(3'd1, 8'hff, 8'h01);
    do_op(3'd2, 8'hff, 8'h00);
    do_op(3'd2, 8'h08, 8'h07);
    do_op(3'd3, 8'h00, 8'h01);
    do_op(3'd3, 8'h80, 8'h01);
    do_op(3'd3, 8'h55, 8'h55);
    do_op(3'd4, 8'h80, 8'h80);

    // R6: class 0 with update, and operation with update low
    write_ccr(8'h97);
    opnd_a = 8'h7f; opnd_b = 8'h7f; alu_res = 8'hfe; op_class = 3'd0; flag_upd = 1;
    step();
    chk("R6 class0", ccr_q, model_ccr());
    opnd_a = 8'h00; opnd_b = 8'h00; alu_res = 8'h00; op_class = 3'd1; flag_upd = 0;
    step();
    chk("R6 upd low", ccr_q, model_ccr());

    // constrained random
    for (int k = 0; k < 400; k++) begin
      do_op(3'($urandom_range(1, 4)), 8'($urandom), 8'($urandom));
    end

    // R9 entry beats clear, vector fetch blocks clear
    write_ccr(8'h00);
    irq_saved = 1; mask_clr = 1; step(); mi = 1;
    chk("R9 entry wins", {7'd0, ccr_q[3]}, 8'd1);
    irq_vec = 1; mask_clr = 1; step();
    chk("R9 vec blocks clr", {7'd0, ccr_q[3]}, 8'd1);
    chk("R12 masked", {7'd0, irq_masked}, 8'd1);

    // R10 return restores whole byte, incl. mask = 0 and fixed bits forced
    rti_byte = 8'h05; rti_load = 1; mask_set = 1; step();
    {mv, mh, mi, mn, mz, mc} = 6'b000101;
    chk("R10 rti", ccr_q, 8'h65);
    chk("R1 fixed after load", ccr_q & 8'h60, 8'h60);

    // R11 priority: rti over write, write over update
    rti_byte = 8'h9e; rti_load = 1; wr_data = 8'h01; wr_en = 1; step();
    chk("R11 rti over write", ccr_q, 8'hfe);
    wr_data = 8'h02; wr_en = 1; opnd_a = 8'h01; opnd_b = 8'h01; alu_res = 8'h02;
    op_class = 3'd1; flag_upd = 1; mask_set = 1; step();
    {mv, mh, mi, mn, mz, mc} = 6'b000010;
    chk("R11 write over upd", ccr_q, 8'h62);

    // R8 set strobe
    mask_set = 1; step(); mi = 1;
    chk("R8 set", ccr_q, model_ccr());
    chk("R12 set", {7'd0, irq_masked}, 8'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule